// File: doc/BRIEF.md
# MIR Receive Frame Parser

This block turns a recovered medium-rate infrared bit stream into received frames. The clock-recovery stage in front of it supplies one line bit per `bitValid` strobe. The parser looks for the 0x7E flag pattern and drops the opening flags, whether one or many. It removes the zero a transmitter inserts after five ones, assembles bytes least-significant bit first, and runs a CRC-16 over everything between the flags. The closing flag ends the frame.

Payload bytes leave on a simple valid/last interface. The two CRC bytes are held back and never forwarded, so `outLast` goes with the final payload byte. Three kinds of error are kept in sticky flags until a read-clear pulse on `statusClear`:

- a frame abort, which is a run of seven or more ones;
- a CRC mismatch;
- a length fault.

The transmit side drives `rxEnable` low while the local transmitter is active. During that time the parser ignores the line.

Top module: `mir_rx_deframer`

## Requirements
- R1: The flag pattern 0x7E is never passed on as data, and back-to-back opening flags are accepted. Bytes are assembled least-significant bit first. Each payload byte appears on `outData` with a one-cycle `outValid` pulse.
- R2: A zero that follows five consecutive ones is removed, so payload bytes 0xFF, 0x7E and 0x3E come out unchanged.
- R3: A closing flag ends a frame (at least one data bit between flags) with a one-cycle `frameEnd` pulse. `outLast` is set with the final payload byte, the two CRC bytes never reach `outData`, and an empty-payload frame gives no output byte.
- R4: Seven consecutive ones inside a frame that already holds eight or more data bits set `abortFlag`. The parser then returns to flag hunting with no `frameEnd` and no `outLast`. A run of ones straight after a flag (idle line) returns to hunting with no status.
- R5: The CRC uses polynomial 0x1021 processed bit-reversed (right shift, constant 0x8408), preset 0xFFFF. It runs over every byte between the flags, including the CRC sent low byte first. At the close of a byte-aligned frame of two or more bytes, a residue other than 0xF0B8 sets `crcErrFlag`.
- R6: A closed frame of fewer than two bytes sets `lenErrFlag`. A frame whose payload exceeds `MAX_PAYLOAD` bytes sets `lenErrFlag` as soon as the excess byte completes and is dropped, with no `frameEnd` and no `outLast`.
- R7: A closing flag that arrives when the data bit count is not a multiple of eight sets `lenErrFlag`, gives `frameEnd` but no `outLast`.
- R8: Each error flag stays set until a `statusClear` pulse, including across later good frames.
- R9: While `rxEnable` is low, strobed bits are ignored. A frame in progress is dropped with no output or status, and hunting restarts.
- R10: `outLast` is only high together with `outValid`. Outputs change only in the cycle after an accepted bit.
- R11: After reset, `outValid`, `outLast`, `frameEnd` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | High to receive; low while the local transmitter is active |
| bitValid | input | 1 | Strobe qualifying `bitIn` |
| bitIn | input | 1 | Recovered line bit |
| statusClear | input | 1 | Read-clear pulse for the error flags |
| outValid | output | 1 | Payload byte valid (one cycle) |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final payload byte of a frame |
| frameEnd | output | 1 | Closing flag received (one cycle) |
| abortFlag | output | 1 | Sticky frame-abort status |
| crcErrFlag | output | 1 | Sticky CRC error status |
| lenErrFlag | output | 1 | Sticky length or alignment error status |

## Verification
The following properties are checked on every cycle:

- `outLast` never appears without `outValid`;
- outputs move only after an accepted bit;
- nothing leaves the block while reception is disabled;
- a CRC error only rises together with `frameEnd`;
- the three flags hold until cleared.

The remaining behaviour needs whole frames and is shown only by the bench's scenarios. This covers removing flags and stuffed zeros from payloads full of ones, withholding the CRC bytes, where `outLast` falls, the CRC residue decision, and the short, oversize, misaligned and aborted frames.

// File: rtl/mir_rx_pkg.sv
package mir_rx_pkg;
  // run of ones that precedes the closing zero of a flag
  localparam int FLAG_RUN = 6;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_INIT     = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

  typedef enum logic {ST_HUNT = 1'b0, ST_FRAME = 1'b1} rxState_t;

  // classification of the current line bit
  typedef struct packed {
    logic isFlag;
    logic isAbort;
    logic isData;
  } lineEvt_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic push;
    logic emitLast;
  } dpStrobe_t;

  // datapath -> control frame state
  typedef struct packed {
    logic anyBits;
    logic aligned;
    logic enough;
    logic haveHeld;
    logic crcGood;
    logic overflow;
  } dpStatus_t;
endpackage

// File: rtl/mir_rx_linedec.sv
module mir_rx_linedec
  import mir_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitStrobe,
  input  logic     flush,
  input  logic     bitIn,
  output lineEvt_t evt
);
  localparam int CNT_W = $clog2(FLAG_RUN + 2);
  localparam logic [CNT_W-1:0] FLAG_CNT  = CNT_W'(FLAG_RUN);
  localparam logic [CNT_W-1:0] STUFF_CNT = CNT_W'(FLAG_RUN - 1);
  localparam logic [CNT_W-1:0] ABORT_CNT = CNT_W'(FLAG_RUN + 1);

  logic [CNT_W-1:0] onesCnt;

  always_comb begin
    evt = '0;
    if (bitIn) begin
      if (onesCnt >= FLAG_CNT) evt.isAbort = 1'b1;
      else                     evt.isData  = 1'b1;
    end else if (onesCnt == FLAG_CNT) begin
      evt.isFlag = 1'b1;
    end else if (onesCnt != STUFF_CNT) begin
      evt.isData = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      onesCnt <= '0;
    end else if (bitStrobe) begin
      if (!bitIn)                    onesCnt <= '0;
      else if (onesCnt != ABORT_CNT) onesCnt <= onesCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mir_rx_datapath.sv
module mir_rx_datapath
  import mir_rx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitIn,
  input  dpStrobe_t  ctl,
  output dpStatus_t  st,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast
);
  localparam int PIPE_D = FLAG_RUN + 1;           // bits of a flag seen before it is recognised
  localparam int FILL_W = $clog2(PIPE_D + 1);
  localparam int HOLD_N = 3;                      // two CRC bytes plus the candidate last byte
  localparam int CNT_W  = $clog2(MAX_PAYLOAD + 3);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_PAYLOAD + 2);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(PIPE_D);

  logic [PIPE_D-1:0] pipe;
  logic [FILL_W-1:0] fill;
  logic              popAny;
  logic [6:0]        shLow;
  logic [2:0]        bitPos;
  logic [CNT_W-1:0]  byteCnt;
  logic [15:0]       crc;
  logic [7:0]        held [HOLD_N];

  logic       pipeFull, popBit;
  logic [7:0] newByte;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REV : 16'h0000);
  endfunction

  assign pipeFull = (fill == FILL_FULL);
  assign popBit   = pipe[PIPE_D-1];
  assign newByte  = {popBit, shLow};

  always_comb begin
    st.anyBits  = popAny;
    st.aligned  = (bitPos == 3'd0);
    st.enough   = (byteCnt >= CNT_W'(2));
    st.haveHeld = (byteCnt >= CNT_W'(HOLD_N));
    st.crcGood  = (crc == CRC_RESIDUE);
    st.overflow = pipeFull && (bitPos == 3'd7) && (byteCnt == CNT_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
      pipe     <= '0;
      fill     <= '0;
      popAny   <= 1'b0;
      shLow    <= '0;
      bitPos   <= '0;
      byteCnt  <= '0;
      crc      <= CRC_INIT;
      for (int i = 0; i < HOLD_N; i++) held[i] <= '0;
    end else begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      if (ctl.emitLast) begin
        outValid <= 1'b1;
        outLast  <= 1'b1;
        outData  <= held[HOLD_N-1];
      end
      if (ctl.clear) begin
        fill    <= '0;
        popAny  <= 1'b0;
        bitPos  <= '0;
        byteCnt <= '0;
        crc     <= CRC_INIT;
      end else if (ctl.push) begin
        pipe <= {pipe[PIPE_D-2:0], bitIn};
        if (!pipeFull) begin
          fill <= fill + 1'b1;
        end else begin
          popAny <= 1'b1;
          crc    <= crcStep(crc, popBit);
          shLow  <= newByte[7:1];
          bitPos <= bitPos + 1'b1;
          if (bitPos == 3'd7) begin
            byteCnt <= byteCnt + 1'b1;
            held[0] <= newByte;
            for (int i = 1; i < HOLD_N; i++) held[i] <= held[i-1];
            if (st.haveHeld) begin
              outValid <= 1'b1;
              outData  <= held[HOLD_N-1];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mir_rx_control.sv
module mir_rx_control
  import mir_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEnable,
  input  logic      bitValid,
  input  lineEvt_t  evt,
  input  dpStatus_t st,
  input  logic      statusClear,
  output dpStrobe_t ctl,
  output logic      frameEnd,
  output logic      abortFlag,
  output logic      crcErrFlag,
  output logic      lenErrFlag
);
  rxState_t state, nextState;
  logic setAbort, setCrc, setLen, endNow;

  always_comb begin
    nextState = state;
    ctl       = '0;
    setAbort  = 1'b0;
    setCrc    = 1'b0;
    setLen    = 1'b0;
    endNow    = 1'b0;
    if (!rxEnable) begin
      ctl.clear = 1'b1;
      nextState = ST_HUNT;
    end else if (bitValid) begin
      unique case (state)
        ST_HUNT: begin
          if (evt.isFlag) begin
            ctl.clear = 1'b1;
            nextState = ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (evt.isFlag) begin
            ctl.clear = 1'b1;
            if (st.anyBits) begin
              endNow = 1'b1;
              if (!st.aligned || !st.enough) setLen = 1'b1;
              else if (!st.crcGood)          setCrc = 1'b1;
              if (st.aligned && st.haveHeld) ctl.emitLast = 1'b1;
            end
          end else if (evt.isAbort) begin
            ctl.clear = 1'b1;
            nextState = ST_HUNT;
            setAbort  = st.anyBits;
          end else if (evt.isData) begin
            if (st.overflow) begin
              ctl.clear = 1'b1;
              nextState = ST_HUNT;
              setLen    = 1'b1;
            end else begin
              ctl.push = 1'b1;
            end
          end
        end
        default: nextState = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_HUNT;
      frameEnd   <= 1'b0;
      abortFlag  <= 1'b0;
      crcErrFlag <= 1'b0;
      lenErrFlag <= 1'b0;
    end else begin
      state      <= nextState;
      frameEnd   <= endNow;
      abortFlag  <= (abortFlag  & ~statusClear) | setAbort;
      crcErrFlag <= (crcErrFlag & ~statusClear) | setCrc;
      lenErrFlag <= (lenErrFlag & ~statusClear) | setLen;
    end
  end
endmodule

// File: rtl/mir_rx_deframer.sv
module mir_rx_deframer
  import mir_rx_pkg::*;
#(
  parameter int MAX_PAYLOAD = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       statusClear,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       frameEnd,
  output logic       abortFlag,
  output logic       crcErrFlag,
  output logic       lenErrFlag
);
  lineEvt_t  lineEvt;
  dpStrobe_t dpCtl;
  dpStatus_t dpSt;

  mir_rx_linedec lineDecI (
    .clk       (clk),
    .rstN      (rstN),
    .bitStrobe (bitValid & rxEnable),
    .flush     (~rxEnable),
    .bitIn     (bitIn),
    .evt       (lineEvt)
  );

  mir_rx_control controlI (
    .clk         (clk),
    .rstN        (rstN),
    .rxEnable    (rxEnable),
    .bitValid    (bitValid),
    .evt         (lineEvt),
    .st          (dpSt),
    .statusClear (statusClear),
    .ctl         (dpCtl),
    .frameEnd    (frameEnd),
    .abortFlag   (abortFlag),
    .crcErrFlag  (crcErrFlag),
    .lenErrFlag  (lenErrFlag)
  );

  mir_rx_datapath #(.MAX_PAYLOAD(MAX_PAYLOAD)) datapathI (
    .clk      (clk),
    .rstN     (rstN),
    .bitIn    (bitIn),
    .ctl      (dpCtl),
    .st       (dpSt),
    .outValid (outValid),
    .outData  (outData),
    .outLast  (outLast)
  );
endmodule

// File: rtl/mir_rx_deframer_chk.sv
module mir_rx_deframer_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnable,
  input logic bitValid,
  input logic statusClear,
  input logic outValid,
  input logic outLast,
  input logic frameEnd,
  input logic abortFlag,
  input logic crcErrFlag,
  input logic lenErrFlag
);
  // R10
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R10
  out_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || frameEnd) |-> $past(bitValid && rxEnable));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!outValid && !frameEnd));

  // R3
  end_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd);

  // R5
  crc_err_at_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcErrFlag) |-> frameEnd);

  // R4
  abort_no_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> !frameEnd);

  // R6
  len_err_on_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lenErrFlag) |-> $past(bitValid && rxEnable));

  // R8
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !statusClear) |=> abortFlag);

  // R8
  crc_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (crcErrFlag && !statusClear) |=> crcErrFlag);

  // R8
  len_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lenErrFlag && !statusClear) |=> lenErrFlag);
endmodule

bind mir_rx_deframer mir_rx_deframer_chk chkI (
  .clk         (clk),
  .rstN        (rstN),
  .rxEnable    (rxEnable),
  .bitValid    (bitValid),
  .statusClear (statusClear),
  .outValid    (outValid),
  .outLast     (outLast),
  .frameEnd    (frameEnd),
  .abortFlag   (abortFlag),
  .crcErrFlag  (crcErrFlag),
  .lenErrFlag  (lenErrFlag)
);

// File: tb/mir_rx_deframer_test.sv
module mir_rx_deframer_test;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic statusClear = 1'b0;
  logic outValid, outLast, frameEnd, abortFlag, crcErrFlag, lenErrFlag;
  logic [7:0] outData;

  int tests = 0;
  int fails = 0;
  int capN = 0;
  int feCnt = 0;
  int onesRun = 0;
  logic [7:0] capData [0:127];
  logic       capLast [0:127];
  logic [7:0] pay [0:15];

  always #10 clk = ~clk;

  mir_rx_deframer #(.MAX_PAYLOAD(MAXP)) uut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .bitValid(bitValid), .bitIn(bitIn),
    .statusClear(statusClear), .outValid(outValid), .outData(outData), .outLast(outLast),
    .frameEnd(frameEnd), .abortFlag(abortFlag), .crcErrFlag(crcErrFlag), .lenErrFlag(lenErrFlag)
  );

  always @(negedge clk) begin
    if (rstN && outValid && capN < 128) begin
      capData[capN] = outData;
      capLast[capN] = outLast;
      capN = capN + 1;
    end
    if (rstN && frameEnd) feCnt = feCnt + 1;
  end

  // length, seed, kind (0 good, 1 bad CRC, 2 misaligned, 3 abort), abort/crc/len expected
  localparam logic [20:0] VECS [8] = '{
    {8'd3, 8'h12, 2'd0, 3'b000},
    {8'd1, 8'hFF, 2'd0, 3'b000},
    {8'd8, 8'hFC, 2'd0, 3'b000},
    {8'd0, 8'h00, 2'd0, 3'b000},
    {8'd6, 8'h7E, 2'd0, 3'b000},
    {8'd4, 8'h3E, 2'd1, 3'b010},
    {8'd4, 8'h55, 2'd2, 3'b001},
    {8'd5, 8'hF8, 2'd3, 3'b100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn = b;
    @(negedge clk);
    bitValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendRaw(input logic [7:0] x);
    for (int i = 0; i < 8; i++) sendBit(x[i]);
  endtask

  task automatic sendStuffBit(input logic b);
    sendBit(b);
    if (b) begin
      onesRun++;
      if (onesRun == 5) begin
        sendBit(1'b0);
        onesRun = 0;
      end
    end else onesRun = 0;
  endtask

  task automatic sendData(input logic [7:0] x);
    for (int i = 0; i < 8; i++) sendStuffBit(x[i]);
  endtask

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ d[i]) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  task automatic clearStatus();
    @(negedge clk);
    statusClear = 1'b1;
    @(negedge clk);
    statusClear = 1'b0;
    capN = 0;
    feCnt = 0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] seed, input int kind);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      pay[i] = seed + 8'(i * 37);
      c = crcByte(c, pay[i]);
    end
    c = ~c;
    if (kind == 1) c = c ^ 16'h0001;
    sendRaw(8'h7E);
    sendRaw(8'h7E);
    onesRun = 0;
    for (int i = 0; i < len; i++) sendData(pay[i]);
    if (kind == 3) begin
      sendRaw(8'hFF);
    end else begin
      sendData(c[7:0]);
      sendData(c[15:8]);
      if (kind == 2) for (int i = 0; i < 3; i++) sendStuffBit(1'b0);
      sendRaw(8'h7E);
    end
    sendRaw(8'hFF);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!outValid && !outLast && !frameEnd, "R11 outputs idle after reset", outValid, 0);
    chk(!abortFlag && !crcErrFlag && !lenErrFlag, "R11 flags clear after reset",
        {abortFlag, crcErrFlag, lenErrFlag}, 0);

    for (int v = 0; v < 8; v++) begin
      int len, kind, expOut, mism, lastCnt, expLast;
      logic [7:0] seed;
      len  = int'(VECS[v][20:13]);
      seed = VECS[v][12:5];
      kind = int'(VECS[v][4:3]);
      clearStatus();
      sendFrame(len, seed, kind);
      expOut = (kind <= 1) ? len : ((kind == 2) ? len - 1 : -1);
      if (expOut >= 0) chk(capN == expOut, "R1 payload byte count", capN, expOut);
      if (kind <= 1) begin
        mism = 0;
        for (int i = 0; i < len && i < capN; i++) if (capData[i] != pay[i]) mism++;
        chk(mism == 0, "R2 de-stuffed payload bytes", mism, 0);
      end
      lastCnt = 0;
      for (int i = 0; i < capN; i++) if (capLast[i]) lastCnt++;
      expLast = (kind <= 1 && len > 0) ? 1 : 0;
      chk(lastCnt == expLast, "R3 last marker count", lastCnt, expLast);
      if (expLast == 1 && capN > 0)
        chk(capLast[capN-1] == 1'b1, "R3 last marker on final byte", capLast[capN-1], 1);
      chk(feCnt == ((kind == 3) ? 0 : 1), "R3 frame end pulses", feCnt, (kind == 3) ? 0 : 1);
      chk(abortFlag == VECS[v][2], "R4 abort flag", abortFlag, VECS[v][2]);
      chk(crcErrFlag == VECS[v][1], "R5 crc flag", crcErrFlag, VECS[v][1]);
      if (kind == 2) chk(lenErrFlag == VECS[v][0], "R7 misaligned length flag", lenErrFlag, 1);
      else           chk(lenErrFlag == VECS[v][0], "R6 length flag", lenErrFlag, VECS[v][0]);
    end

    // R6 single byte between flags
    clearStatus();
    sendRaw(8'h7E);
    onesRun = 0;
    sendData(8'hA5);
    sendRaw(8'h7E);
    sendRaw(8'hFF);
    repeat (4) @(negedge clk);
    chk(lenErrFlag == 1'b1, "R6 short frame flag", lenErrFlag, 1);
    chk(capN == 0 && feCnt == 1, "R6 short frame output", capN, 0);

    // R6 oversize payload dropped
    clearStatus();
    sendFrame(MAXP + 1, 8'h21, 0);
    chk(lenErrFlag == 1'b1, "R6 oversize flag", lenErrFlag, 1);
    chk(feCnt == 0, "R6 oversize no frame end", feCnt, 0);
    lastChk: begin
      int lc;
      lc = 0;
      for (int i = 0; i < capN; i++) if (capLast[i]) lc++;
      chk(lc == 0, "R6 oversize no last", lc, 0);
    end
    chk(crcErrFlag == 1'b0, "R6 oversize no crc flag", crcErrFlag, 0);

    // R9 reception disabled mid frame
    clearStatus();
    sendRaw(8'h7E);
    onesRun = 0;
    sendData(8'h11);
    sendData(8'h22);
    sendData(8'h33);
    rxEnable = 1'b0;
    sendRaw(8'h7E);
    sendRaw(8'h44);
    rxEnable = 1'b1;
    onesRun = 0;
    sendData(8'h55);
    sendData(8'h66);
    sendRaw(8'h7E);
    sendRaw(8'hFF);
    repeat (4) @(negedge clk);
    chk(capN == 0 && feCnt == 0, "R9 disabled frame dropped", capN + feCnt, 0);
    chk(!abortFlag && !crcErrFlag && !lenErrFlag, "R9 no status from dropped frame",
        {abortFlag, crcErrFlag, lenErrFlag}, 0);
    sendFrame(2, 8'h40, 0);
    chk(capN == 2 && capData[1] == pay[1], "R9 recovery after enable", capN, 2);

    // R8 sticky status across a good frame, then read-clear
    clearStatus();
    sendFrame(3, 8'h09, 1);
    sendFrame(3, 8'h0A, 0);
    chk(crcErrFlag == 1'b1, "R8 crc flag held across good frame", crcErrFlag, 1);
    clearStatus();
    @(negedge clk);
    chk(crcErrFlag == 1'b0, "R8 crc flag cleared", crcErrFlag, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule